// File: doc/BRIEF.md
# Debug Command Register with Inactivity Timeout

This block holds the 8-bit command byte of a single-wire background debug port. A serial shift engine outside the block delivers each received command byte with a one-cycle load strobe. In a special peripheral mode, a parallel bus can also write the byte and read it back. The upper six bits are decoded into command attributes:
- a hardware-versus-firmware flag,
- a flag that says a data phase follows,
- a read/write direction,
- an enter-background request,
- a word/byte size,
- a debug/user address space.

The two lowest bits always read as zero.

The block watches a pulse that marks each falling edge seen from the host. If the host leaves the line quiet for a whole timeout window, the block clears the command byte. The block also keeps the select that chooses which clock times the serial traffic. A new select value is held in a shadow register. The value moves into the active select only at the start of a command, and only after a fixed guard window following the previous command's data phase has run out. When the bus clock is slower than the dedicated debug clock, the block forces the bus clock no matter what the select holds.

Top module: `dbg_cmd_reg`

## Requirements
- R1: After reset, `cmd_byte`, every field output, `bus_rdata` and `clk_sel_active` are zero, and `use_bus_clk` equals `bus_slow`.
- R2: A `ser_load` pulse stores `{ser_byte[7:2], 2'b00}` into `cmd_byte` on the next clock edge. Bits 1:0 of `cmd_byte` are always zero.
- R3: The field outputs follow the stored byte: `hw_cmd` is bit 7 (1 means a hardware command), `data_follows` is bit 6, `rw_dir` is bit 5, `enter_bgnd` is bit 4, `word_size` is bit 3 and `dbg_space` is bit 2.
- R4: A `bus_wr` pulse stores `{bus_wdata[7:2], 2'b00}` only while `periph_mode` is 1. While `periph_mode` is 0, the write has no effect.
- R5: `bus_rdata` equals `cmd_byte` while `bus_rd` and `periph_mode` are both 1, and is zero otherwise (combinational).
- R6: An idle counter restarts at 0 on every `host_fall` pulse. When it reaches TIMEOUT_CYC (default 512) clock cycles without a pulse, `cmd_byte` is cleared on that same edge.
- R7: The idle counter saturates at TIMEOUT_CYC. After one clear, a byte loaded later is not cleared again until a `host_fall` pulse has restarted the count and a full window has passed.
- R8: When a timeout clear falls on the same edge as a serial load or a bus write, the clear wins.
- R11: When a serial load and a bus write happen on the same edge, the serial load wins.
- R9: `sel_wr` stores `sel_val` in a pending select. A `cmd_end` pulse starts a guard window of POST_CYC (default 150) cycles. The pending value is copied into `clk_sel_active` by the first `cmd_start` sampled strictly after the window has expired. A `cmd_start` that is sampled on the edge where the window expires, or earlier, leaves `clk_sel_active` unchanged.
- R10: `use_bus_clk` is 1 whenever `bus_slow` is 1. Otherwise it equals `clk_sel_active`, where 0 selects the dedicated debug clock and 1 selects the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_mode | input | 1 | Special peripheral mode; enables bus access |
| ser_load | input | 1 | Strobe from the shift engine: a command byte is ready |
| ser_byte | input | 8 | Serially received command byte |
| bus_wr | input | 1 | Parallel bus write strobe |
| bus_rd | input | 1 | Parallel bus read enable |
| bus_wdata | input | 8 | Parallel bus write data |
| bus_rdata | output | 8 | Parallel bus read data |
| host_fall | input | 1 | One-cycle pulse for each host falling edge |
| sel_wr | input | 1 | Strobe: a command writes the clock select |
| sel_val | input | 1 | New clock select value |
| cmd_start | input | 1 | Pulse at the start of a debug command |
| cmd_end | input | 1 | Pulse at the end of a command's data phase |
| bus_slow | input | 1 | 1 when the bus clock is slower than the debug clock |
| cmd_byte | output | 8 | Stored command byte |
| hw_cmd | output | 1 | Hardware (1) or firmware (0) command |
| data_follows | output | 1 | A data phase follows the command |
| rw_dir | output | 1 | Read/write direction |
| enter_bgnd | output | 1 | Enter-background request |
| word_size | output | 1 | Word (1) or byte (0) access |
| dbg_space | output | 1 | Debug/user space select |
| clk_sel_active | output | 1 | Active clock select as stored |
| use_bus_clk | output | 1 | Effective timing clock: 1 means bus clock |

## Verification
A wrong idle count shows up at `cmd_byte`. The byte either vanishes before TIMEOUT_CYC quiet cycles have passed, or survives past them. The error is visible on the exact edge where the window closes. A wrong guard-window count or a wrong armed state moves the change of `clk_sel_active` one command earlier or later. A shadow select that was captured wrongly gives the wrong value at the first qualifying `cmd_start`. Errors in load priority or in bus gating appear at `cmd_byte` or `bus_rdata` one edge after the stimulus.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam int unsigned CMD_W = 8;

    // Command byte: attribute flags from bit 7 down, two reserved zeros.
    typedef struct packed {
        logic       hw;
        logic       data;
        logic       rw;
        logic       bgnd;
        logic       word;
        logic       space;
        logic [1:0] rsvd;
    } cmd_t;

    function automatic cmd_t to_cmd(input logic [CMD_W-1:0] raw);
        cmd_t c;
        c      = cmd_t'(raw);
        c.rsvd = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/dbg_idle_timer.sv
module dbg_idle_timer #(
    parameter int unsigned TIMEOUT_CYC = 512
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               host_fall,
    output logic                               timeout_hit,
    output logic [$clog2(TIMEOUT_CYC+1)-1:0]   idle_cnt
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] FULL = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        if (host_fall) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != FULL) begin
            st_d.cnt = st_q.cnt + CW'(1);
            hit_d    = (st_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timeout_hit = hit_d;
    assign idle_cnt    = st_q.cnt;
endmodule

// File: rtl/dbg_cmd_store.sv
module dbg_cmd_store
    import dbg_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ser_load,
    input  logic [CMD_W-1:0] ser_byte,
    input  logic             bus_wr,
    input  logic             periph_mode,
    input  logic [CMD_W-1:0] bus_wdata,
    output cmd_t             cmd
);
    typedef struct packed {
        cmd_t cmd;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)                       st_d.cmd = '0;
        else if (ser_load)               st_d.cmd = to_cmd(ser_byte);
        else if (bus_wr && periph_mode)  st_d.cmd = to_cmd(bus_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd = st_q.cmd;
endmodule

// File: rtl/dbg_clk_switch.sv
module dbg_clk_switch #(
    parameter int unsigned POST_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_wr,
    input  logic sel_val,
    input  logic cmd_start,
    input  logic cmd_end,
    input  logic bus_slow,
    output logic sel_active,
    output logic sel_armed,
    output logic use_bus_clk
);
    localparam int unsigned WW = $clog2(POST_CYC + 1);
    localparam logic [WW-1:0] LOAD = WW'(POST_CYC);

    typedef struct packed {
        logic          pend;
        logic          act;
        logic          arm;
        logic [WW-1:0] win;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr) st_d.pend = sel_val;
        if (cmd_start && st_q.arm) st_d.act = st_q.pend;

        if (cmd_end) begin
            st_d.win = LOAD;
            st_d.arm = 1'b0;
        end else begin
            if (st_q.win != '0) st_d.win = st_q.win - WW'(1);
            if (cmd_start && st_q.arm)     st_d.arm = 1'b0;
            else if (st_q.win == WW'(1))   st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_active  = st_q.act;
    assign sel_armed   = st_q.arm;
    assign use_bus_clk = st_q.act | bus_slow;
endmodule

// File: rtl/dbg_cmd_reg.sv
module dbg_cmd_reg
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 512,
    parameter int unsigned POST_CYC    = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       periph_mode,
    input  logic       ser_load,
    input  logic [7:0] ser_byte,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       host_fall,
    input  logic       sel_wr,
    input  logic       sel_val,
    input  logic       cmd_start,
    input  logic       cmd_end,
    input  logic       bus_slow,
    output logic [7:0] cmd_byte,
    output logic       hw_cmd,
    output logic       data_follows,
    output logic       rw_dir,
    output logic       enter_bgnd,
    output logic       word_size,
    output logic       dbg_space,
    output logic       clk_sel_active,
    output logic       use_bus_clk
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

    logic          timeout_hit;
    logic [CW-1:0] idle_cnt;
    logic          sel_armed;
    cmd_t          cmd;

    dbg_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_fall   (host_fall),
        .timeout_hit (timeout_hit),
        .idle_cnt    (idle_cnt)
    );

    dbg_cmd_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (timeout_hit),
        .ser_load    (ser_load),
        .ser_byte    (ser_byte),
        .bus_wr      (bus_wr),
        .periph_mode (periph_mode),
        .bus_wdata   (bus_wdata),
        .cmd         (cmd)
    );

    dbg_clk_switch #(.POST_CYC(POST_CYC)) u_switch (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr      (sel_wr),
        .sel_val     (sel_val),
        .cmd_start   (cmd_start),
        .cmd_end     (cmd_end),
        .bus_slow    (bus_slow),
        .sel_active  (clk_sel_active),
        .sel_armed   (sel_armed),
        .use_bus_clk (use_bus_clk)
    );

    assign cmd_byte     = cmd;
    assign hw_cmd       = cmd.hw;
    assign data_follows = cmd.data;
    assign rw_dir       = cmd.rw;
    assign enter_bgnd   = cmd.bgnd;
    assign word_size    = cmd.word;
    assign dbg_space    = cmd.space;
    assign bus_rdata    = (bus_rd && periph_mode) ? cmd : '0;
endmodule

// File: rtl/dbg_cmd_reg_chk.sv
module dbg_cmd_reg_chk #(
    parameter int unsigned TIMEOUT_CYC = 512
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             periph_mode,
    input logic                             ser_load,
    input logic [7:0]                       ser_byte,
    input logic                             bus_wr,
    input logic                             host_fall,
    input logic                             cmd_start,
    input logic                             bus_slow,
    input logic [7:0]                       cmd_byte,
    input logic                             clk_sel_active,
    input logic                             use_bus_clk,
    input logic                             timeout_hit,
    input logic [$clog2(TIMEOUT_CYC+1)-1:0] idle_cnt
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_byte[1:0] == 2'b00);

    assert_serial_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_load && !timeout_hit) |=> cmd_byte == {$past(ser_byte[7:2]), 2'b00});

    assert_bus_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !periph_mode && !ser_load && !timeout_hit) |=> $stable(cmd_byte));

    assert_timeout_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |=> cmd_byte == 8'h00);

    assert_fall_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_fall |=> idle_cnt == '0);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= CW'(TIMEOUT_CYC));

    assert_single_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == CW'(TIMEOUT_CYC)) |-> !timeout_hit);

    assert_switch_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_start |=> $stable(clk_sel_active));

    assert_slow_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_slow |-> use_bus_clk);
endmodule

bind dbg_cmd_reg dbg_cmd_reg_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .periph_mode    (periph_mode),
    .ser_load       (ser_load),
    .ser_byte       (ser_byte),
    .bus_wr         (bus_wr),
    .host_fall      (host_fall),
    .cmd_start      (cmd_start),
    .bus_slow       (bus_slow),
    .cmd_byte       (cmd_byte),
    .clk_sel_active (clk_sel_active),
    .use_bus_clk    (use_bus_clk),
    .timeout_hit    (timeout_hit),
    .idle_cnt       (idle_cnt)
);

// File: tb/test_dbg_cmd_reg.sv
module test_dbg_cmd_reg;
    localparam int TMO  = 512;
    localparam int POST = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_mode, ser_load, bus_wr, bus_rd, host_fall;
    logic       sel_wr, sel_val, cmd_start, cmd_end, bus_slow;
    logic [7:0] ser_byte, bus_wdata, bus_rdata, cmd_byte;
    logic       hw_cmd, data_follows, rw_dir, enter_bgnd, word_size, dbg_space;
    logic       clk_sel_active, use_bus_clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0] m_cmd;
    int         m_cnt, m_win;
    logic       m_pend, m_act, m_arm;

    always #2 clk = ~clk;

    dbg_cmd_reg i_dbg_cmd_reg (.*);

    function automatic logic [7:0] exp_cmd_next(input logic [7:0] cur, input int cnt);
        if (!host_fall && cnt == TMO - 1) return 8'h00;
        if (ser_load)                     return {ser_byte[7:2], 2'b00};
        if (bus_wr && periph_mode)        return {bus_wdata[7:2], 2'b00};
        return cur;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [7:0] cur);
        return (bus_rd && periph_mode) ? cur : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        periph_mode = 0; ser_load = 0; bus_wr = 0; bus_rd = 0; host_fall = 0;
        sel_wr = 0; sel_val = 0; cmd_start = 0; cmd_end = 0; bus_slow = 0;
        ser_byte = 0; bus_wdata = 0;
    endtask

    // Called at a falling edge with inputs set; advances one clock.
    task automatic tick();
        logic [7:0] n_cmd;
        int n_cnt, n_win;
        logic n_pend, n_act, n_arm;
        #1;
        chk("R5 bus_rdata", bus_rdata, exp_rdata(m_cmd));
        chk("R10 use_bus_clk", {7'd0, use_bus_clk}, {7'd0, m_act | bus_slow});
        n_cmd  = exp_cmd_next(m_cmd, m_cnt);
        n_cnt  = host_fall ? 0 : (m_cnt < TMO ? m_cnt + 1 : m_cnt);
        n_pend = sel_wr ? sel_val : m_pend;
        n_act  = (cmd_start && m_arm) ? m_pend : m_act;
        n_win  = m_win;
        n_arm  = m_arm;
        if (cmd_end) begin
            n_win = POST; n_arm = 0;
        end else begin
            if (m_win > 0) n_win = m_win - 1;
            if (cmd_start && m_arm) n_arm = 0;
            else if (m_win == 1)    n_arm = 1;
        end
        @(posedge clk);
        @(negedge clk);
        m_cmd = n_cmd; m_cnt = n_cnt; m_pend = n_pend; m_act = n_act;
        m_win = n_win; m_arm = n_arm;
        chk("R2 R4 R6 R8 R11 cmd_byte", cmd_byte, m_cmd);
        chk("R3 fields", {hw_cmd, data_follows, rw_dir, enter_bgnd, word_size, dbg_space, 2'b00},
            m_cmd);
        chk("R9 clk_sel_active", {7'd0, clk_sel_active}, {7'd0, m_act});
    endtask

    task automatic idle_ticks(input int n);
        idle_in();
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        idle_in();
        m_cmd = 0; m_cnt = 0; m_win = 0; m_pend = 0; m_act = 0; m_arm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 cmd_byte", cmd_byte, 8'h00);
        chk("R1 clk_sel_active", {7'd0, clk_sel_active}, 8'h00);
        chk("R1 use_bus_clk", {7'd0, use_bus_clk}, 8'h00);
        #1;
        @(negedge clk);

        // R2/R3: serial load with reserved bits set
        idle_in(); ser_load = 1; ser_byte = 8'hFF; host_fall = 1; tick();
        chk("R2 reserved bits cleared", cmd_byte, 8'hFC);
        idle_in(); ser_load = 1; ser_byte = 8'hA7; tick();
        chk("R3 hw/rw/space", {hw_cmd, data_follows, rw_dir, enter_bgnd, word_size, dbg_space, 2'b00},
            8'hA4);

        // R4: bus write ignored outside peripheral mode, accepted inside
        idle_in(); bus_wr = 1; bus_wdata = 8'h3C; tick();
        chk("R4 write ignored", cmd_byte, 8'hA4);
        idle_in(); bus_wr = 1; periph_mode = 1; bus_wdata = 8'h3B; tick();
        chk("R4 write taken", cmd_byte, 8'h38);

        // R5: read gating
        idle_in(); bus_rd = 1; #1;
        chk("R5 read gated off", bus_rdata, 8'h00);
        periph_mode = 1; #1;
        chk("R5 read enabled", bus_rdata, 8'h38);
        tick();

        // R11: serial beats bus write
        idle_in(); ser_load = 1; ser_byte = 8'h44; bus_wr = 1; periph_mode = 1; bus_wdata = 8'h88;
        host_fall = 1; tick();
        chk("R11 serial priority", cmd_byte, 8'h44);

        // R6: clear exactly at the end of the quiet window
        idle_ticks(TMO - 1);
        chk("R6 held before window end", cmd_byte, 8'h44);
        idle_ticks(1);
        chk("R6 cleared at window end", cmd_byte, 8'h00);

        // R7: saturated counter does not clear again
        idle_in(); ser_load = 1; ser_byte = 8'h80; tick();
        idle_ticks(TMO + 100);
        chk("R7 no second clear", cmd_byte, 8'h80);

        // R8: timeout beats a same-edge bus write
        idle_in(); host_fall = 1; tick();
        idle_ticks(TMO - 1);
        idle_in(); bus_wr = 1; periph_mode = 1; bus_wdata = 8'hF0; tick();
        chk("R8 clear beats write", cmd_byte, 8'h00);

        // R9: deferred clock switch
        idle_in(); sel_wr = 1; sel_val = 1; cmd_end = 1; host_fall = 1; tick();
        idle_ticks(POST - 1);
        idle_in(); cmd_start = 1; tick();
        chk("R9 start at expiry edge ignored", {7'd0, clk_sel_active}, 8'h00);
        idle_in(); bus_slow = 1; #1;
        chk("R10 slow bus forces", {7'd0, use_bus_clk}, 8'h01);
        idle_in(); cmd_start = 1; tick();
        chk("R9 switched after window", {7'd0, clk_sel_active}, 8'h01);

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            idle_in();
            periph_mode = ($urandom % 2) == 0;
            ser_load    = ($urandom % 12) == 0;
            ser_byte    = 8'($urandom);
            bus_wr      = ($urandom % 6) == 0;
            bus_wdata   = 8'($urandom);
            bus_rd      = ($urandom % 3) == 0;
            host_fall   = ($urandom % 700) == 0;
            sel_wr      = ($urandom % 40) == 0;
            sel_val     = 1'($urandom);
            cmd_start   = ($urandom % 25) == 0;
            cmd_end     = ($urandom % 220) == 0;
            bus_slow    = ($urandom % 5) == 0;
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule